// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one channel that moves data between memory and a single selected peripheral. It has two buffers, A and B. Each buffer has a start pointer and a byte count, and software arms each one on its own. While the channel runs, it serves the buffer named by a side bit. Each time the peripheral raises a request, the channel performs one burst of device-width transfers. When a buffer's count reaches zero, the channel marks that buffer finished, disarms it and switches to the other side. Software can therefore refill one buffer while the other one streams.

Control and status bits are changed through two write-only words. At one word, each 1 bit sets the matching status bit. At the other word, each 1 bit clears it. A third word reads the status back. A configuration word holds the transfer direction, the byte order, the burst length, the device width, a 4-bit peripheral select and a packed peripheral address. The memory port issues one single-cycle access per transfer. The peripheral acknowledge is strobed in the same cycle.

Top module: `ppdma_channel`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `mem_valid` and `dev_ack` are low.
- R2: Register words are selected by `reg_word`:
  - 0: configuration.
  - 1: set strobe.
  - 2: clear strobe.
  - 3: status.
  - 4 and 5: buffer A pointer and count.
  - 6 and 7: buffer B pointer and count.
  - Words 1 and 2 read as zero. Only the low 13 bits of a count are stored.
- R3: A write to word 1 sets each status bit written as 1. A write to word 2 clears each status bit written as 1. Bits written as 0 keep their value. A write to word 3 changes nothing.
- R4: The status bits are:
  - bit 0: run.
  - bit 1: interrupt enable.
  - bit 2: error.
  - bit 3: A finished.
  - bit 4: A armed.
  - bit 5: B finished.
  - bit 6: B armed.
  - bit 7: side (0 = A, 1 = B).
- R5: Transfers happen only while run is set and the current side is armed. A request seen while the channel is idle starts exactly one burst. The burst length is 4 transfers when configuration bit 2 is 0 and 8 when it is 1. A burst is shorter if fewer transfers remain.
- R6: Each transfer moves 1 byte when configuration bit 3 is 0, or 2 bytes when it is 1. After each transfer, the pointer advances by that many bytes and the count drops by the same amount, both visible on readback.
- R7: When a count reaches zero, the buffer's armed bit clears, its finished bit sets and the side bit toggles. If the new side is armed, service continues. If it is not, the channel idles without error.
- R8: Clearing run during a burst lets the burst finish, and no further burst starts.
- R9: If the serviced buffer is armed, the device is 16-bit and the count is odd, the channel sets error, clears run and makes no transfer.
- R10: `irq` is high exactly when interrupt enable is set and at least one of error, A finished or B finished is set.
- R11: Configuration bit 0 sets the direction. With 0, memory data is read and driven on `dev_wdata`. With 1, `dev_rdata` is written to memory. An 8-bit device uses only the low byte, and the high byte is zero.
- R12: For a 16-bit device with configuration bit 1 set, the two bytes are swapped between the two sides. With bit 1 clear, the data passes through unchanged.
- R13: `dev_sel` equals configuration bits [7:4]. `dev_addr` is built from configuration bits [31:28] as address bits [31:28] and configuration bits [27:8] as address bits [21:2]; all other address bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_word` |
| mem_valid | output | 1 | Memory access this cycle |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, same cycle |
| dev_req | input | 1 | Peripheral burst request |
| dev_ack | output | 1 | Peripheral transfer strobe |
| dev_rdata | input | 16 | Data from the peripheral |
| dev_wdata | output | 16 | Data to the peripheral |
| dev_sel | output | 4 | Peripheral select |
| dev_addr | output | 32 | Decoded peripheral address |
| irq | output | 1 | Interrupt request |

## Verification
Most faults in the channel's state show up at the ports within one clock:
- A wrong pointer or side bit appears on `mem_addr` at the next transfer.
- A lost armed or run bit shows as a missing or extra `mem_valid` cycle.
- A miscounted burst shows as a run of strobes of the wrong length.

The bench keeps a behavioural model of the status, pointers and counts. Every cycle it compares the transfer strobes, addresses, data lanes, interrupt and the word currently selected for readback. A divergence is therefore reported in the cycle it first reaches a port.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;

    localparam int REG_W       = 32;
    localparam int LANE_W      = 16;
    localparam int BEAT_W      = 4;
    localparam int SHORT_BURST = 4;
    localparam int LONG_BURST  = 8;

    // register word indices
    localparam logic [2:0] RW_CFG   = 3'd0;
    localparam logic [2:0] RW_SET   = 3'd1;
    localparam logic [2:0] RW_CLR   = 3'd2;
    localparam logic [2:0] RW_STAT  = 3'd3;
    localparam logic [2:0] RW_A_PTR = 3'd4;
    localparam logic [2:0] RW_A_LEN = 3'd5;
    localparam logic [2:0] RW_B_PTR = 3'd6;
    localparam logic [2:0] RW_B_LEN = 3'd7;

    // status bit positions
    localparam int SB_RUN    = 0;
    localparam int SB_IE     = 1;
    localparam int SB_ERR    = 2;
    localparam int SB_DONE_A = 3;
    localparam int SB_GO_A   = 4;
    localparam int SB_DONE_B = 5;
    localparam int SB_GO_B   = 6;
    localparam int SB_SIDE   = 7;

    typedef struct packed {
        logic [23:0] dev_field;
        logic [3:0]  sel;
        logic        wide;
        logic        long_burst;
        logic        big;
        logic        to_mem;
    } dev_cfg_t;

    typedef enum logic {XS_IDLE, XS_BURST} xfer_state_e;

    function automatic logic [LANE_W-1:0] lane_fmt(input logic [LANE_W-1:0] d,
                                                   input logic wide, input logic big);
        if (!wide)
            return {8'h00, d[7:0]};
        else if (big)
            return {d[7:0], d[15:8]};
        else
            return d;
    endfunction

    function automatic logic [REG_W-1:0] dev_address(input dev_cfg_t c);
        return {c.dev_field[23:20], 6'b000000, c.dev_field[19:0], 2'b00};
    endfunction

endpackage

// File: rtl/ppdma_regs.sv
module ppdma_regs
    import ppdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        idx,
    input  logic [REG_W-1:0]  wdata,
    input  logic              hw_upd,
    input  logic [ADDR_W-1:0] hw_ptr,
    input  logic [CNT_W-1:0]  hw_len,
    input  logic              hw_done,
    input  logic              hw_err,
    output dev_cfg_t          cfg,
    output logic [7:0]        stat,
    output logic [ADDR_W-1:0] ptr [2],
    output logic [CNT_W-1:0]  len [2],
    output logic [REG_W-1:0]  rdata
);

    logic [7:0] stat_n;
    logic       side;

    assign side = stat[SB_SIDE];

    always_comb begin
        stat_n = stat;
        if (we && idx == RW_SET) stat_n = stat_n | wdata[7:0];
        if (we && idx == RW_CLR) stat_n = stat_n & ~wdata[7:0];
        if (hw_err) begin
            stat_n[SB_ERR] = 1'b1;
            stat_n[SB_RUN] = 1'b0;
        end
        if (hw_done) begin
            if (side) begin
                stat_n[SB_DONE_B] = 1'b1;
                stat_n[SB_GO_B]   = 1'b0;
            end else begin
                stat_n[SB_DONE_A] = 1'b1;
                stat_n[SB_GO_A]   = 1'b0;
            end
            stat_n[SB_SIDE] = ~side;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            cfg  <= '0;
        end else begin
            stat <= stat_n;
            if (we && idx == RW_CFG) cfg <= dev_cfg_t'(wdata);
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_buf
        localparam logic [2:0] PTR_IDX = RW_A_PTR + 3'(2 * b);
        localparam logic [2:0] LEN_IDX = RW_A_PTR + 3'(2 * b + 1);
        logic [ADDR_W-1:0] ptr_q;
        logic [CNT_W-1:0]  len_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q <= '0;
                len_q <= '0;
            end else if (hw_upd && side == 1'(b)) begin
                ptr_q <= hw_ptr;
                len_q <= hw_len;
            end else if (we) begin
                if (idx == PTR_IDX) ptr_q <= wdata[ADDR_W-1:0];
                if (idx == LEN_IDX) len_q <= wdata[CNT_W-1:0];
            end
        end

        assign ptr[b] = ptr_q;
        assign len[b] = len_q;
    end

    always_comb begin
        case (idx)
            RW_CFG:   rdata = REG_W'(cfg);
            RW_STAT:  rdata = REG_W'(stat);
            RW_A_PTR: rdata = REG_W'(ptr[0]);
            RW_A_LEN: rdata = REG_W'(len[0]);
            RW_B_PTR: rdata = REG_W'(ptr[1]);
            RW_B_LEN: rdata = REG_W'(len[1]);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/ppdma_xfer.sv
module ppdma_xfer
    import ppdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              go,
    input  logic [ADDR_W-1:0] ptr_cur,
    input  logic [CNT_W-1:0]  len_cur,
    input  dev_cfg_t          cfg,
    input  logic              dev_req,
    output logic              active,
    output logic              hw_upd,
    output logic [ADDR_W-1:0] hw_ptr,
    output logic [CNT_W-1:0]  hw_len,
    output logic              hw_done,
    output logic              hw_err
);

    xfer_state_e       state;
    logic [BEAT_W-1:0] beats_left;
    logic [BEAT_W-1:0] first_beats;
    logic [CNT_W-1:0]  units;
    logic [CNT_W-1:0]  blen;
    logic [CNT_W-1:0]  len_next;
    logic              armed;
    logic              misalign;

    assign armed    = (state == XS_IDLE) && run && go;
    assign misalign = cfg.wide && len_cur[0];
    assign units    = cfg.wide ? (len_cur >> 1) : len_cur;
    assign blen     = cfg.long_burst ? CNT_W'(LONG_BURST) : CNT_W'(SHORT_BURST);
    assign first_beats = (units < blen) ? units[BEAT_W-1:0] : blen[BEAT_W-1:0];

    assign len_next = len_cur - {{(CNT_W-2){1'b0}}, cfg.wide, ~cfg.wide};
    assign hw_ptr   = ptr_cur + {{(ADDR_W-2){1'b0}}, cfg.wide, ~cfg.wide};
    assign hw_len   = len_next;

    assign active  = (state == XS_BURST);
    assign hw_upd  = active;
    assign hw_err  = armed && misalign;
    assign hw_done = (armed && !misalign && len_cur == '0) ||
                     (active && len_next == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= XS_IDLE;
            beats_left <= '0;
        end else begin
            case (state)
                XS_IDLE: begin
                    if (armed && !misalign && len_cur != '0 && dev_req) begin
                        state      <= XS_BURST;
                        beats_left <= first_beats;
                    end
                end
                XS_BURST: begin
                    beats_left <= beats_left - 1'b1;
                    if (beats_left == BEAT_W'(1) || len_next == '0)
                        state <= XS_IDLE;
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ppdma_lane.sv
module ppdma_lane
    import ppdma_pkg::*;
(
    input  dev_cfg_t          cfg,
    input  logic [LANE_W-1:0] mem_rdata,
    input  logic [LANE_W-1:0] dev_rdata,
    output logic [LANE_W-1:0] mem_wdata,
    output logic [LANE_W-1:0] dev_wdata
);

    assign mem_wdata = lane_fmt(dev_rdata, cfg.wide, cfg.big);
    assign dev_wdata = lane_fmt(mem_rdata, cfg.wide, cfg.big);

endmodule

// File: rtl/ppdma_channel.sv
module ppdma_channel
    import ppdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_word,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              dev_req,
    output logic              dev_ack,
    input  logic [15:0]       dev_rdata,
    output logic [15:0]       dev_wdata,
    output logic [3:0]        dev_sel,
    output logic [31:0]       dev_addr,
    output logic              irq
);

    dev_cfg_t          cfg;
    logic [7:0]        stat;
    logic [ADDR_W-1:0] ptr [2];
    logic [CNT_W-1:0]  len [2];
    logic              side;
    logic              active;
    logic              hw_upd;
    logic              hw_done;
    logic              hw_err;
    logic [ADDR_W-1:0] hw_ptr;
    logic [CNT_W-1:0]  hw_len;

    assign side = stat[SB_SIDE];

    ppdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .we(reg_we), .idx(reg_word), .wdata(reg_wdata),
        .hw_upd(hw_upd), .hw_ptr(hw_ptr), .hw_len(hw_len),
        .hw_done(hw_done), .hw_err(hw_err),
        .cfg(cfg), .stat(stat), .ptr(ptr), .len(len), .rdata(reg_rdata)
    );

    ppdma_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xfer (
        .clk(clk), .rst(rst),
        .run(stat[SB_RUN]),
        .go(side ? stat[SB_GO_B] : stat[SB_GO_A]),
        .ptr_cur(ptr[side]), .len_cur(len[side]),
        .cfg(cfg), .dev_req(dev_req),
        .active(active), .hw_upd(hw_upd), .hw_ptr(hw_ptr), .hw_len(hw_len),
        .hw_done(hw_done), .hw_err(hw_err)
    );

    ppdma_lane u_lane (
        .cfg(cfg), .mem_rdata(mem_rdata), .dev_rdata(dev_rdata),
        .mem_wdata(mem_wdata), .dev_wdata(dev_wdata)
    );

    assign mem_valid = active;
    assign dev_ack   = active;
    assign mem_write = cfg.to_mem;
    assign mem_addr  = ptr[side];
    assign dev_sel   = cfg.sel;
    assign dev_addr  = dev_address(cfg);
    assign irq       = stat[SB_IE] &&
                       (stat[SB_ERR] || stat[SB_DONE_A] || stat[SB_DONE_B]);

endmodule

// File: rtl/ppdma_chk.sv
module ppdma_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              reg_we,
    input logic [2:0]        reg_word,
    input logic [31:0]       reg_rdata,
    input logic              irq,
    input logic [7:0]        stat,
    input logic              wide,
    input logic              long_burst
);

    logic [3:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)            run_len <= '0;
        else if (mem_valid) run_len <= run_len + 1'b1;
        else                run_len <= '0;
    end

    // R5
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (run_len < (long_burst ? 4'd8 : 4'd4)));

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && $past(mem_valid) && !$past(reg_we)) |->
        (mem_addr == $past(mem_addr) + (wide ? ADDR_W'(2) : ADDR_W'(1))));

    // R8
    no_start_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_valid) |-> $past(stat[0]));

    // R9
    err_halt_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(stat[2]) && !$past(reg_we)) |-> !stat[0]);

    // R7
    side_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(stat[3]) && !$past(reg_we)) |-> stat[7]);

    // R10
    irq_map_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_word == 3'd3) |->
        (irq == (reg_rdata[1] && (reg_rdata[2] || reg_rdata[3] || reg_rdata[5]))));

endmodule

bind ppdma_channel ppdma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .reg_we(reg_we), .reg_word(reg_word), .reg_rdata(reg_rdata), .irq(irq),
    .stat(stat), .wide(cfg.wide), .long_burst(cfg.long_burst)
);

// File: tb/sim_ppdma_channel.sv
`timescale 1ns/1ps
module sim_ppdma_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_word = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_valid, mem_write, dev_ack, irq;
    logic [31:0] mem_addr, dev_addr;
    logic [15:0] mem_wdata, mem_rdata, dev_wdata;
    logic [15:0] dev_rdata = 16'h1357;
    logic        dev_req = 1'b0;
    logic [3:0]  dev_sel;

    int n_chk = 0;
    int n_err = 0;
    int xfers = 0;
    bit live  = 0;

    always #4 clk = ~clk;

    ppdma_channel u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_req(dev_req), .dev_ack(dev_ack), .dev_rdata(dev_rdata),
        .dev_wdata(dev_wdata), .dev_sel(dev_sel), .dev_addr(dev_addr), .irq(irq)
    );

    // memory contents are a fixed function of the address
    function automatic logic [15:0] mem_fn(input logic [31:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] ^ 8'hC3};
    endfunction
    assign mem_rdata = mem_fn(mem_addr);

    always @(posedge clk) dev_rdata <= dev_rdata + 16'h0123;

    function automatic logic [15:0] fmt(input logic [15:0] d, input logic [31:0] c);
        if (c[3] == 1'b0) return {8'h00, d[7:0]};
        if (c[1] == 1'b1) return {d[7:0], d[15:8]};
        return d;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cfg;
    logic [7:0]  m_st, m_nst;
    logic [31:0] m_ptr [2];
    int          m_len [2];
    bit          m_busy;
    int          m_beats;
    int          ms, mw, mbl, mnl;
    bit          mdn, mer, mup;

    always @(posedge clk) begin
        if (rst) begin
            m_cfg = '0; m_st = '0; m_busy = 0; m_beats = 0;
            m_ptr[0] = '0; m_ptr[1] = '0; m_len[0] = 0; m_len[1] = 0;
        end else begin
            ms  = int'(m_st[7]);
            mw  = m_cfg[3] ? 2 : 1;
            mbl = m_cfg[2] ? 8 : 4;
            mdn = 0; mer = 0; mup = 0; mnl = 0;
            if (m_busy) begin
                mup = 1;
                mnl = m_len[ms] - mw;
                m_beats--;
                if (mnl == 0) mdn = 1;
                if (m_beats == 0 || mnl == 0) m_busy = 0;
            end else if (m_st[0] && m_st[4 + 2*ms]) begin
                if (m_cfg[3] && (m_len[ms] % 2 == 1)) mer = 1;
                else if (m_len[ms] == 0) mdn = 1;
                else if (dev_req) begin
                    m_busy  = 1;
                    m_beats = (m_len[ms] / mw < mbl) ? m_len[ms] / mw : mbl;
                end
            end
            m_nst = m_st;
            if (reg_we) begin
                case (reg_word)
                    3'd0: m_cfg = reg_wdata;
                    3'd1: m_nst = m_nst | reg_wdata[7:0];
                    3'd2: m_nst = m_nst & ~reg_wdata[7:0];
                    3'd4: m_ptr[0] = reg_wdata;
                    3'd5: m_len[0] = int'(reg_wdata & 32'h1FFF);
                    3'd6: m_ptr[1] = reg_wdata;
                    3'd7: m_len[1] = int'(reg_wdata & 32'h1FFF);
                    default: ;
                endcase
            end
            if (mer) begin m_nst[2] = 1'b1; m_nst[0] = 1'b0; end
            if (mdn) begin
                m_nst[3 + 2*ms] = 1'b1;
                m_nst[4 + 2*ms] = 1'b0;
                m_nst[7] = ~m_st[7];
            end
            if (mup) begin
                m_ptr[ms] = m_ptr[ms] + 32'(mw);
                m_len[ms] = mnl;
            end
            m_st = m_nst;
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] w);
        case (w)
            3'd0: return m_cfg;
            3'd3: return {24'h0, m_st};
            3'd4: return m_ptr[0];
            3'd5: return 32'(m_len[0]);
            3'd6: return m_ptr[1];
            3'd7: return 32'(m_len[1]);
            default: return 32'h0;
        endcase
    endfunction

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #1;
        if (live) begin
            logic [31:0] e_addr;
            e_addr = m_ptr[m_st[7]];
            chk("R5 mem_valid", 32'(mem_valid), 32'(m_busy));
            chk("R5 dev_ack", 32'(dev_ack), 32'(m_busy));
            chk("R11 mem_write", 32'(mem_write), 32'(m_cfg[0]));
            chk("R10 irq", 32'(irq), 32'(m_st[1] && (m_st[2] || m_st[3] || m_st[5])));
            chk("R2 reg_rdata", reg_rdata, m_read(reg_word));
            chk("R13 dev_sel", 32'(dev_sel), 32'(m_cfg[7:4]));
            if (m_busy) begin
                chk("R6 mem_addr", mem_addr, e_addr);
                if (m_cfg[0])
                    chk("R12 mem_wdata", 32'(mem_wdata), 32'(fmt(dev_rdata, m_cfg)));
                else
                    chk("R12 dev_wdata", 32'(dev_wdata), 32'(fmt(mem_fn(e_addr), m_cfg)));
            end
            if (mem_valid) xfers++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_word = w; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_word = 3'd3; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [31:0] d);
        @(negedge clk);
        reg_word = w;
        #2 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #1_200_000;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        live = 1;

        // R1 reset state
        for (int w = 0; w < 8; w++) begin
            rd(3'(w), v);
            chk("R1 reset readback", v, 32'h0);
        end
        chk("R1 irq after reset", 32'(irq), 32'h0);
        chk("R1 mem_valid after reset", 32'(mem_valid), 32'h0);

        // R2 map and count masking
        wr(3'd4, 32'h0000_0100);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, v); chk("R2 count keeps 13 bits", v, 32'h0000_1FFF);
        rd(3'd4, v); chk("R2 pointer A readback", v, 32'h0000_0100);
        wr(3'd1, 32'h0000_0002);
        rd(3'd1, v); chk("R2 set word reads zero", v, 32'h0);
        rd(3'd2, v); chk("R2 clear word reads zero", v, 32'h0);

        // R3 / R4 set, clear and ignored write
        rd(3'd3, v); chk("R3 set interrupt enable", v, 32'h0000_0002);
        wr(3'd3, 32'h0000_00FF);
        rd(3'd3, v); chk("R3 write to status word ignored", v, 32'h0000_0002);
        wr(3'd2, 32'h0000_0000);
        rd(3'd3, v); chk("R3 zero bits keep value", v, 32'h0000_0002);
        wr(3'd2, 32'h0000_0002);
        rd(3'd3, v); chk("R4 status cleared", v, 32'h0);

        // R5/R6/R7: 16-bit little, memory->device, burst 4, A then B
        wr(3'd0, 32'h0000_0008);
        wr(3'd4, 32'h0000_0100); wr(3'd5, 32'd12);
        wr(3'd6, 32'h0000_0200); wr(3'd7, 32'd4);
        xfers = 0;
        dev_req = 1'b1;
        wr(3'd1, 32'h0000_0051);
        idle(40);
        chk("R5 transfers over both buffers", 32'(xfers), 32'd8);
        rd(3'd3, v); chk("R7 both finished, side back to A", v, 32'h0000_0029);
        rd(3'd5, v); chk("R6 count A drained", v, 32'h0);
        rd(3'd4, v); chk("R6 pointer A advanced", v, 32'h0000_010C);
        rd(3'd6, v); chk("R6 pointer B advanced", v, 32'h0000_0204);

        // R7 other side not armed: idle, then resume when armed
        wr(3'd2, 32'h0000_00FF);
        wr(3'd0, 32'h0000_0000);
        wr(3'd4, 32'h0000_0300); wr(3'd5, 32'd5);
        xfers = 0;
        wr(3'd1, 32'h0000_0011);
        idle(40);
        chk("R7 A drained in 8-bit units", 32'(xfers), 32'd5);
        rd(3'd3, v); chk("R7 idles on unarmed B", v, 32'h0000_0089);
        wr(3'd6, 32'h0000_0400); wr(3'd7, 32'd2);
        wr(3'd1, 32'h0000_0040);
        idle(20);
        chk("R7 B served after arming", 32'(xfers), 32'd7);
        rd(3'd3, v); chk("R7 status after B", v, 32'h0000_0029);

        // R8 clear run mid-burst, burst of 8
        wr(3'd2, 32'h0000_00FF);
        wr(3'd0, 32'h0000_0004);
        wr(3'd4, 32'h0000_0500); wr(3'd5, 32'd20);
        xfers = 0;
        wr(3'd1, 32'h0000_0011);
        do @(negedge clk); while (!mem_valid);
        wr(3'd2, 32'h0000_0001);
        idle(30);
        chk("R8 burst finishes after stop", 32'(xfers), 32'd8);
        rd(3'd5, v); chk("R8 count left after stop", v, 32'd12);
        rd(3'd3, v); chk("R8 A still armed, run clear", v, 32'h0000_0010);

        // R9 / R10 odd count on a 16-bit device
        wr(3'd2, 32'h0000_00FF);
        wr(3'd0, 32'h0000_0008);
        wr(3'd5, 32'd3);
        xfers = 0;
        wr(3'd1, 32'h0000_0013);
        idle(6);
        chk("R9 no transfer on odd count", 32'(xfers), 32'd0);
        rd(3'd3, v); chk("R9 error set and run cleared", v, 32'h0000_0016);
        chk("R10 irq raised by error", 32'(irq), 32'h1);
        wr(3'd2, 32'h0000_0004);
        @(negedge clk); #1;
        chk("R10 irq drops after clearing error", 32'(irq), 32'h0);

        // R11 / R12 device->memory, 16-bit big endian
        wr(3'd2, 32'h0000_00FF);
        wr(3'd0, 32'h0000_000B);
        wr(3'd4, 32'h0000_0600); wr(3'd5, 32'd8);
        xfers = 0;
        wr(3'd1, 32'h0000_0011);
        do @(negedge clk); while (!mem_valid);
        #1;
        chk("R11 write direction", 32'(mem_write), 32'h1);
        chk("R12 bytes swapped", 32'(mem_wdata), 32'({dev_rdata[7:0], dev_rdata[15:8]}));
        idle(20);
        chk("R11 four 16-bit words moved", 32'(xfers), 32'd4);
        dev_req = 1'b0;

        // R13 select and address decode
        wr(3'd2, 32'h0000_00FF);
        wr(3'd0, 32'hA123_45B0);
        @(negedge clk); #1;
        chk("R13 dev_sel", 32'(dev_sel), 32'h0000_000B);
        chk("R13 dev_addr", dev_addr, 32'hA004_8D14);

        idle(4);
        finish_run();
    end

endmodule